// File: doc/BRIEF.md
# Mains-Cycle Elapsed Timer

This block keeps a 24-bit running count of mains power cycles. An external circuit delivers one strobe per line cycle. That strobe has no fixed relation to the system clock, so the block first brings it into the clock domain. It then advances the count once for each rising edge it sees. On 60 Hz power one count is 16 2/3 ms, so 60 counts make a second and 3600 counts make a minute. A count that starts at zero takes roughly 77 hours to run out.

Software picks an interval of N line cycles by writing the value 2^24 − N into the counter. When the counter steps past all ones it returns to zero and raises a latched timer interrupt request. The request stays set until the interrupt controller acknowledges it. An external mask can hold back the request line without losing the pending event. In the interrupt scheme this request sits second in priority, below I/O and above arithmetic overflow. The ranking itself is done outside this block.

Top module: `line_tick_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `count_o` is 0, `irq_pend` is 0 and `irq_req` is 0.
- R2: The tick input passes through two synchronizing flops. Each rising edge of `tick_async` advances `count_o` by exactly one, and the new value appears after the third rising clock edge that follows the tick edge. A tick held high counts only once.
- R3: When `load_en` is high at a clock edge, `count_o` takes `load_val` at that edge.
- R4: If a load and a synchronized tick edge fall in the same cycle, the load value is kept and that tick is lost.
- R5: A tick at count 24'hFFFFFF returns the count to 0, sets `irq_pend` at the same edge, and later ticks continue counting from 0.
- R6: After a load of 2^24 − N, `irq_pend` stays low for the first N − 1 ticks and rises on tick N.
- R7: `irq_pend` stays high until `irq_ack` is sampled high, and then clears at that edge. If a wrap happens at the same edge as the acknowledge, `irq_pend` stays set.
- R8: `irq_req` equals `irq_pend` gated by the mask sampled at the same edge: while `irq_mask` is 1, `irq_req` is 0 after the next edge, and `irq_pend` is not affected by the mask.
- R9: A load never sets or clears `irq_pend`. This includes a load of 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_async | input | 1 | Line-cycle strobe, asynchronous to `clk` |
| load_en | input | 1 | Write `load_val` into the counter |
| load_val | input | 24 | Value to load |
| irq_mask | input | 1 | 1 blocks the request output |
| irq_ack | input | 1 | Clears the pending request |
| count_o | output | 24 | Current count |
| irq_pend | output | 1 | Latched wrap event |
| irq_req | output | 1 | Masked interrupt request |

## Verification
If the synchronizer or edge detector were wrong, `count_o` would move at the wrong clock edge or more than once per strobe. This shows within three cycles of a tick edge. If the counter or the load priority were wrong, the fault would show on `count_o` in the cycle after the collision or load. If the request latch were wrong, `irq_pend` would miss or keep a wrap event. That shows one edge after a wrap or an acknowledge, and `irq_req` follows one edge after the mask changes.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  parameter int unsigned LTT_CNT_W = 24;
  parameter int unsigned LTT_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/ltt_sync_edge.sv
module ltt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain;

  generate
    genvar g;
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // chain[LAST] is the history flop used only for edge detection
  assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/ltt_counter.sv
module ltt_counter
  import ltt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cnt_op_e op;

  always_comb begin
    if (load_en)   op = CNT_LOAD;
    else if (step) op = CNT_STEP;
    else           op = CNT_HOLD;
  end

  assign wrap_evt = (op == CNT_STEP) && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (op)
        CNT_LOAD: count <= load_val;
        CNT_STEP: count <= count + 1'b1;
        default:  count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ltt_irq_latch.sv
module ltt_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic ack,
  input  logic mask,
  output logic pend,
  output logic req
);
  logic pend_nxt;

  always_comb begin
    if (set_evt)  pend_nxt = 1'b1;
    else if (ack) pend_nxt = 1'b0;
    else          pend_nxt = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      req  <= pend_nxt & ~mask;
    end
  end
endmodule

// File: rtl/line_tick_timer.sv
module line_tick_timer
  import ltt_pkg::*;
#(
  parameter int unsigned CNT_W       = LTT_CNT_W,
  parameter int unsigned SYNC_STAGES = LTT_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_async,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_mask,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_pend,
  output logic             irq_req
);
  logic tick_rise;
  logic wrap_evt;

  ltt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (tick_async),
    .rise (tick_rise)
  );

  ltt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .step     (tick_rise),
    .count    (count_o),
    .wrap_evt (wrap_evt)
  );

  ltt_irq_latch u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (wrap_evt),
    .ack     (irq_ack),
    .mask    (irq_mask),
    .pend    (irq_pend),
    .req     (irq_req)
  );
endmodule

// File: rtl/ltt_checker.sv
module ltt_checker #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_async,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             irq_mask,
  input logic             irq_ack,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_pend,
  input logic             irq_req
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !irq_pend && !irq_req)); // R1

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count_o == $past(load_val))); // R3

  AST_WRAP_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    (!load_en && count_o == TOP) |=> (count_o == TOP || (count_o == '0 && irq_pend))); // R5

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !irq_ack) |=> irq_pend); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && (count_o != TOP || load_en)) |=> !irq_pend); // R7

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_req); // R8

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_pend); // R8

  AST_LOAD_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (load_en && !irq_pend) |=> !irq_pend); // R9
endmodule

bind line_tick_timer ltt_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/line_tick_timer_bench.sv
module line_tick_timer_bench;
  localparam int W = 24;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_async = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         irq_mask = 1'b0;
  logic         irq_ack = 1'b0;
  logic [W-1:0] count_o;
  logic         irq_pend;
  logic         irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_tick_timer u_line_tick_timer (
    .clk(clk), .rst(rst), .tick_async(tick_async), .load_en(load_en),
    .load_val(load_val), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .count_o(count_o), .irq_pend(irq_pend), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) tick_async = 1'b1;
    repeat (4) @(negedge clk);
    tick_async = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk) begin load_en = 1'b1; load_val = v; end
    @(negedge clk) load_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(irq_pend == 0 && irq_req == 0, "R1 irq", {irq_pend, irq_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(count_o == 0, "R1 after release", count_o, 0);
  endtask

  task automatic t_tick_timing();
    logic [W-1:0] base;
    base = count_o;
    @(negedge clk) tick_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(count_o == base, "R2 not before third edge", count_o, base);
    @(negedge clk);
    chk(count_o == base + 1'b1, "R2 third edge", count_o, base + 1'b1);
    repeat (5) @(negedge clk);
    chk(count_o == base + 1'b1, "R2 level counts once", count_o, base + 1'b1);
    tick_async = 1'b0;
    repeat (3) @(negedge clk);
    pulse();
    pulse();
    chk(count_o == base + 3, "R2 three pulses", count_o, base + 3);
  endtask

  task automatic t_load();
    do_load(24'h123456);
    chk(count_o == 24'h123456, "R3 load", count_o, 24'h123456);
    pulse();
    chk(count_o == 24'h123457, "R3 count from load", count_o, 24'h123457);
  endtask

  task automatic t_collide();
    @(negedge clk) tick_async = 1'b1;
    @(negedge clk);
    @(negedge clk) begin load_en = 1'b1; load_val = 24'd100; end
    @(negedge clk) load_en = 1'b0;
    chk(count_o == 24'd100, "R4 load wins", count_o, 100);
    repeat (4) @(negedge clk);
    chk(count_o == 24'd100, "R4 tick dropped", count_o, 100);
    tick_async = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_wrap();
    do_load(TOP);
    chk(irq_pend == 0, "R9 load of max no set", irq_pend, 0);
    pulse();
    chk(count_o == 0, "R5 wraps to zero", count_o, 0);
    chk(irq_pend == 1, "R5 pend set", irq_pend, 1);
    chk(irq_req == 1, "R8 req unmasked", irq_req, 1);
    pulse();
    chk(count_o == 1, "R5 keeps counting", count_o, 1);
    chk(irq_pend == 1, "R7 pend held", irq_pend, 1);
    do_ack();
    chk(irq_pend == 0 && irq_req == 0, "R7 ack clears", {irq_pend, irq_req}, 0);
  endtask

  task automatic t_interval();
    do_load(24'd16777216 - 24'd5);
    for (int i = 1; i < 5; i++) begin
      pulse();
      chk(irq_pend == 0, "R6 no early pend", irq_pend, 0);
    end
    pulse();
    chk(irq_pend == 1 && count_o == 0, "R6 pend on tick N", {irq_pend, count_o}, {1'b1, 24'd0});
  endtask

  task automatic t_ack_collide();
    do_load(TOP);
    @(negedge clk) tick_async = 1'b1;
    @(negedge clk);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(count_o == 0, "R7 wrap with ack count", count_o, 0);
    chk(irq_pend == 1, "R7 wrap beats ack", irq_pend, 1);
    tick_async = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mask();
    @(negedge clk) irq_mask = 1'b1;
    @(negedge clk);
    chk(irq_req == 0, "R8 masked", irq_req, 0);
    chk(irq_pend == 1, "R8 pend unaffected", irq_pend, 1);
    @(negedge clk) irq_mask = 1'b0;
    @(negedge clk);
    chk(irq_req == 1, "R8 unmasked again", irq_req, 1);
  endtask

  task automatic t_load_keeps();
    do_load(24'd7);
    chk(irq_pend == 1 && count_o == 7, "R9 load keeps pend", {irq_pend, count_o}, {1'b1, 24'd7});
    do_ack();
    chk(irq_pend == 0, "R7 ack after load", irq_pend, 0);
  endtask

  initial begin
    t_reset();
    t_tick_timing();
    t_load();
    t_collide();
    t_wrap();
    t_interval();
    t_ack_collide();
    t_mask();
    t_load_keeps();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule